// File: doc/BRIEF.md
# Two-Level Interrupt Arbiter

This block collects interrupt requests from two external pins and from a parameterised set of on-chip peripheral sources. It picks the most urgent pending request and weighs it against the two core mask bits from the status register. When that request may interrupt, it raises a one-cycle accept strobe. With the strobe it gives the vector address and the mask value the core should load next. The core forms the vector itself for the two pin interrupts. For a peripheral, the vector that peripheral supplies is passed through unchanged.

There are two priority levels. Level 1 can never be masked. Level 0 is allowed only while the core mask is clear. Each external pin passes through a two-flop synchronizer. A per-pin select chooses between level-sensitive operation and edge-latched operation. In edge-latched operation a rising edge stays pending until it is granted. An active-low reset clears every registered output and every latched request.

Top module: `exc_arbiter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `take_o` is 0, `vec_o` is 0 and `mask_o` is 0.
- R2: A level-1 request is accepted for every value of `sr_mask_i`.
- R3: The mask is `sr_mask_i` = {I1,I0}. A level-0 request is accepted only when `sr_mask_i` is 2'b00. Any nonzero value blocks level 0.
- R4: Among the accepted requests, level 1 beats level 0. Within one level the order is pin A, then pin B, then peripheral 0, 1, and so on upward.
- R5: The vector for pin A is VEC_A (default 8'h10), and for pin B it is VEC_A+VEC_STEP (default 8'h12). For peripheral i it is `per_vec_i[i*VW +: VW]`.
- R6: When a level-0 request is accepted, `mask_o` is 2'b01. When a level-1 request is accepted, `mask_o` is 2'b11. In a cycle with no accept, `take_o`, `vec_o` and `mask_o` are all 0.
- R7: A peripheral request appears on the outputs after the next clock edge. In level mode, a pin change appears after the third clock edge following it.
- R8: In edge mode (`edge_sel_i` bit set), a one-cycle pulse on the pin stays pending while masked. Once allowed, it is accepted exactly once.
- R9: In level mode, a pin that has returned low produces no request once it has passed the synchronizer.
- R10: Reset discards an edge-latched request that has not been granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a_i | input | 1 | External interrupt pin A (asynchronous) |
| pin_b_i | input | 1 | External interrupt pin B (asynchronous) |
| edge_sel_i | input | 2 | Per pin (bit0 = A, bit1 = B): 1 = edge-latched, 0 = level |
| pin_lvl_i | input | 2 | Per pin priority level (bit0 = A, bit1 = B) |
| per_req_i | input | NPER | Peripheral request lines |
| per_lvl_i | input | NPER | Peripheral priority levels |
| per_vec_i | input | NPER*VW | Peripheral-supplied vectors, VW bits each |
| sr_mask_i | input | 2 | Core mask bits {I1,I0} |
| take_o | output | 1 | Accept strobe |
| vec_o | output | VW | Vector address of the accepted request |
| mask_o | output | 2 | Mask value to load on accept |

## Verification
The hardest situation to reach is an edge-latched pin request that has to wait: the pin pulses once while level 0 is masked, and the request must survive until the mask clears, or be destroyed by a reset that arrives first. The bench gets there with a single-cycle pulse under a nonzero mask and several idle cycles. It then either clears the mask and watches for exactly one accept, or asserts reset and watches that nothing is ever accepted. Peripheral arbitration is swept over every combination of request, level and mask for four sources.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic pend;
    } sync_st_t;

    localparam logic [1:0] MASK_OPEN = 2'b00;
    localparam logic [1:0] MASK_LO   = 2'b01;
    localparam logic [1:0] MASK_HI   = 2'b11;

endpackage

// File: rtl/exc_ext_sync.sv
module exc_ext_sync
    import exc_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic edge_i,
    input  logic taken_i,
    output logic req_o
);

    sync_st_t st_d, st_q;
    logic     rise;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        rise    = st_q.s2 & ~st_q.s3;
        req_o   = edge_i ? (st_q.pend | rise) : st_q.s2;
        st_d.pend = edge_i & (st_q.pend | rise) & ~taken_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && st_q.pend && !taken_i) |=> st_q.pend);

    // R8
    pend_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && st_q.pend) |-> req_o);

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] lvl_i,
    input  logic         allow_lo_i,
    output logic [N-1:0] gnt_o,
    output logic         hit_o,
    output logic         hi_o
);

    logic [N-1:0] elig, hi_req;
    logic [N:0]   blk_hi, blk_any;
    logic [N-1:0] gnt_hi, gnt_any;

    assign elig   = req_i & (lvl_i | {N{allow_lo_i}});
    assign hi_req = req_i & lvl_i;
    assign blk_hi[0]  = 1'b0;
    assign blk_any[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt_hi[i]    = hi_req[i] & ~blk_hi[i];
        assign gnt_any[i]   = elig[i]   & ~blk_any[i];
        assign blk_hi[i+1]  = blk_hi[i]  | hi_req[i];
        assign blk_any[i+1] = blk_any[i] | elig[i];
    end

    assign hi_o  = blk_hi[N];
    assign hit_o = blk_any[N];
    assign gnt_o = hi_o ? gnt_hi : gnt_any;

    always_comb begin
        // R4
        gnt_onehot_chk: assert ($onehot0(gnt_o));
        // R3
        gnt_legal_chk: assert ((gnt_o & ~elig) == '0);
    end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_arb_pkg::*;
#(
    parameter int          NPER     = 4,
    parameter int          VW       = 8,
    parameter int unsigned VEC_A    = 16,
    parameter int unsigned VEC_STEP = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin_a_i,
    input  logic                pin_b_i,
    input  logic [1:0]          edge_sel_i,
    input  logic [1:0]          pin_lvl_i,
    input  logic [NPER-1:0]     per_req_i,
    input  logic [NPER-1:0]     per_lvl_i,
    input  logic [NPER*VW-1:0]  per_vec_i,
    input  logic [1:0]          sr_mask_i,
    output logic                take_o,
    output logic [VW-1:0]       vec_o,
    output logic [1:0]          mask_o
);

    localparam int NSRC = NPER + 2;
    localparam logic [VW-1:0] VEC_PIN_A = VW'(VEC_A);
    localparam logic [VW-1:0] VEC_PIN_B = VW'(VEC_A + VEC_STEP);

    typedef struct packed {
        logic          take;
        logic [VW-1:0] vec;
        logic [1:0]    mask;
    } out_st_t;

    out_st_t          out_d, out_q;
    logic [1:0]       pin_req;
    logic [NSRC-1:0]  src_req, src_lvl, gnt;
    logic             hit, hi;

    exc_ext_sync u_sync_a (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_a_i), .edge_i(edge_sel_i[0]),
        .taken_i(gnt[0]), .req_o(pin_req[0])
    );

    exc_ext_sync u_sync_b (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_b_i), .edge_i(edge_sel_i[1]),
        .taken_i(gnt[1]), .req_o(pin_req[1])
    );

    assign src_req = {per_req_i, pin_req};
    assign src_lvl = {per_lvl_i, pin_lvl_i};

    exc_prio_pick #(.N(NSRC)) u_pick (
        .req_i(src_req), .lvl_i(src_lvl), .allow_lo_i(sr_mask_i == MASK_OPEN),
        .gnt_o(gnt), .hit_o(hit), .hi_o(hi)
    );

    always_comb begin
        out_d      = '0;
        out_d.take = hit;
        if (hit) out_d.mask = hi ? MASK_HI : MASK_LO;
        if (gnt[0]) out_d.vec = VEC_PIN_A;
        if (gnt[1]) out_d.vec = VEC_PIN_B;
        for (int i = 0; i < NPER; i++) begin
            if (gnt[i+2]) out_d.vec = per_vec_i[i*VW +: VW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign take_o = out_q.take;
    assign vec_o  = out_q.vec;
    assign mask_o = out_q.mask;

    // R6
    mask_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (mask_o == MASK_LO || mask_o == MASK_HI));

    // R3
    lo_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && mask_o == MASK_LO) |-> $past(sr_mask_i) == MASK_OPEN);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (vec_o == '0 && mask_o == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !take_o);

endmodule

// File: tb/exc_arbiter_bench.sv
module exc_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_a = 1'b0, pin_b = 1'b0;
    logic [1:0] edge_sel = 2'b00, pin_lvl = 2'b00;
    logic [3:0] per_req = '0, per_lvl = '0;
    logic [31:0] per_vec;
    logic [1:0] sr_mask = 2'b00;
    logic       take;
    logic [7:0] vec;
    logic [1:0] mask;
    int         checks = 0, errors = 0;
    bit         done = 0;

    assign per_vec = {8'h4C, 8'h48, 8'h44, 8'h40};

    always #2 clk = ~clk;

    exc_arbiter u_exc_arbiter (
        .clk(clk), .rst_n(rst_n), .pin_a_i(pin_a), .pin_b_i(pin_b),
        .edge_sel_i(edge_sel), .pin_lvl_i(pin_lvl), .per_req_i(per_req),
        .per_lvl_i(per_lvl), .per_vec_i(per_vec), .sr_mask_i(sr_mask),
        .take_o(take), .vec_o(vec), .mask_o(mask)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic t, input logic [7:0] v, input logic [1:0] m);
        checks++;
        if (take !== t || vec !== v || mask !== m) begin
            errors++;
            $display("FAIL %s: got take=%0b vec=%02h mask=%02b, expected take=%0b vec=%02h mask=%02b",
                     tag, take, vec, mask, t, v, m);
        end
    endtask

    function automatic void expect_per(input logic [3:0] rq, input logic [3:0] lv,
                                       input logic [1:0] m, output logic t,
                                       output logic [7:0] v, output logic [1:0] nm);
        t = 0; v = 0; nm = 0;
        for (int i = 0; i < 4; i++)
            if (!t && rq[i] && lv[i]) begin t = 1; v = 8'h40 + 8'(i * 4); nm = 2'b11; end
        if (m == 2'b00)
            for (int i = 0; i < 4; i++)
                if (!t && rq[i]) begin t = 1; v = 8'h40 + 8'(i * 4); nm = 2'b01; end
    endfunction

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic t; logic [7:0] v; logic [1:0] nm;
        // R1: reset state
        tick(); tick();
        check("R1 in reset", 0, 8'h00, 2'b00);
        rst_n = 1'b1;
        tick();
        check("R1 after reset", 0, 8'h00, 2'b00);

        // R2 R3 R4 R5 R6: exhaustive peripheral sweep
        for (int m = 0; m < 4; m++)
            for (int r = 0; r < 16; r++)
                for (int l = 0; l < 16; l++) begin
                    sr_mask = 2'(m); per_req = 4'(r); per_lvl = 4'(l);
                    expect_per(4'(r), 4'(l), 2'(m), t, v, nm);
                    tick();
                    check("R2/R3/R4/R5/R6 peripheral sweep", t, v, nm);
                end
        per_req = '0; sr_mask = 2'b00;
        tick();

        // R7: level-mode pin latency, R5 pin A vector
        pin_lvl = 2'b00; edge_sel = 2'b00;
        pin_a = 1'b1;
        tick(); tick();
        check("R7 pin not yet visible", 0, 8'h00, 2'b00);
        tick();
        check("R7 R5 pin A taken", 1, 8'h10, 2'b01);
        // R4: pin A beats peripheral at level 0
        per_req = 4'b0001; per_lvl = 4'b0000;
        tick();
        check("R4 pin A over peripheral", 1, 8'h10, 2'b01);
        // R4: level-1 pin B beats level-0 pin A
        pin_lvl = 2'b10; pin_b = 1'b1;
        tick(); tick(); tick();
        check("R4 R5 pin B level 1", 1, 8'h12, 2'b11);
        // R4: level-1 peripheral loses to level-1 pin B
        per_lvl = 4'b0001;
        tick();
        check("R4 pin B over level-1 peripheral", 1, 8'h12, 2'b11);
        per_req = '0; per_lvl = '0;
        // R9: pins low in level mode give no request
        pin_a = 1'b0; pin_b = 1'b0;
        tick(); tick(); tick();
        check("R9 level pins released", 0, 8'h00, 2'b00);
        tick();
        check("R9 level pins stay idle", 0, 8'h00, 2'b00);

        // R8: edge pulse held while masked, taken once
        pin_lvl = 2'b00; edge_sel = 2'b01; sr_mask = 2'b01;
        pin_a = 1'b1;
        tick();
        pin_a = 1'b0;
        for (int k = 0; k < 6; k++) begin
            tick();
            check("R3 R8 masked edge held", 0, 8'h00, 2'b00);
        end
        sr_mask = 2'b00;
        tick();
        check("R8 edge taken on unmask", 1, 8'h10, 2'b01);
        tick();
        check("R8 edge taken only once", 0, 8'h00, 2'b00);
        tick();
        check("R8 edge stays cleared", 0, 8'h00, 2'b00);

        // R10: reset discards a latched edge
        sr_mask = 2'b01;
        pin_a = 1'b1;
        tick();
        pin_a = 1'b0;
        tick(); tick(); tick();
        rst_n = 1'b0;
        tick();
        check("R1 R10 in reset", 0, 8'h00, 2'b00);
        rst_n = 1'b1;
        sr_mask = 2'b00;
        for (int k = 0; k < 5; k++) begin
            tick();
            check("R10 latched edge discarded", 0, 8'h00, 2'b00);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule